// File: doc/BRIEF.md
# Bipolar Line Code Decoder for T1 and E1 Receive Paths

This block turns the dual-rail symbol stream of a T1/J1 or E1 receiver into a single-rail NRZ bit stream. Each recovered bit period delivers one symbol: a pulse on the positive rail, a pulse on the negative rail, or neither. The block sits behind clock and data recovery. It runs on a fast system clock and advances only when the one-cycle `bitEn` strobe marks the active edge of the recovered bit clock.

In decode mode the block tracks pulse polarity and marks bipolar violations. With the code-select input set, it also removes zero substitutions: the eight-symbol B8ZS pattern at the T1 rate and the four-symbol HDB3 patterns at the E1 rate. Symbols travel through a look-ahead pipeline so that a substitution can be recognised in full and scrubbed to zeros before its first bit reaches the output. The same pipeline length is used whatever the code selection, so a change of code does not reorder bits. The block also raises two event flags for downstream status logic, one for violations and one for runs of excessive zeros. When the receive interface is in a dual-rail mode, decoding is bypassed and the raw rails are passed on.

Top module: `bipolar_decoder`

## Requirements
- R1: After reset, and before any `bitEn` strobe, all four outputs are 0.
- R2: The outputs change only in the clock cycle after a `bitEn` strobe, or when a mode input changes. Between strobes they hold.
- R3: In decode mode (`singleRail`=1), a symbol with a pulse on either rail is decoded as 1 and an empty symbol as 0, and `rxDataN` is 0. A symbol sampled on strobe k appears on `rxDataP` after strobe k+7 at the T1 rate (`rateE1`=0) or after strobe k+3 at the E1 rate (`rateE1`=1), whatever the value of `codeSel`.
- R4: A pulse with the same polarity as the previous single-rail pulse is a violation. The first pulse after reset is never a violation. With `codeSel`=0, every violation raises `bpvFlag` while its own bit is on `rxDataP`, and that bit reads 1.
- R5: Pulses on both rails in one symbol form a violation that is decoded as 1. Such a symbol does not update the polarity reference.
- R6: At the T1 rate with `codeSel`=1, the sequence zero, zero, zero, V, B, zero, V, B (V a violation, B a valid pulse) is output as eight zeros with no violation flag. With `codeSel`=0, the same stream is decoded symbol by symbol.
- R7: At the E1 rate with `codeSel`=1, the sequence zero, zero, zero, V is output as four zeros with no violation flag.
- R8: At the E1 rate with `codeSel`=1, the sequence B, zero, zero, V is output as four zeros with no violation flag.
- R9: With `codeSel`=1, a violation that does not complete a substitution pattern is output as 1 with `bpvFlag` set.
- R10: At the T1 rate, `exzFlag` is high for exactly one bit period, together with the 16th consecutive output symbol that carried no line pulse. It is only raised after at least one pulse has left the pipeline since reset or since leaving bypass.
- R11: At the E1 rate, `exzFlag` is high for exactly one bit period, together with the 4th consecutive output symbol that carried no line pulse. Substituted zeros still count as pulses.
- R12: In bypass (`singleRail`=0), `rxDataP` and `rxDataN` show the `posRail` and `negRail` values sampled at the latest strobe. Both flags stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitEn | input | 1 | One-cycle strobe at each active recovered-clock edge |
| posRail | input | 1 | Positive-polarity pulse present in this bit period |
| negRail | input | 1 | Negative-polarity pulse present in this bit period |
| rateE1 | input | 1 | 0: T1/J1 rate, 1: E1 rate |
| codeSel | input | 1 | 0: AMI, 1: zero-substitution code (B8ZS at T1, HDB3 at E1) |
| singleRail | input | 1 | 1: decode to single-rail NRZ, 0: bypass raw rails |
| rxDataP | output | 1 | Decoded NRZ data, or raw positive rail in bypass |
| rxDataN | output | 1 | 0 when decoding, raw negative rail in bypass |
| bpvFlag | output | 1 | Violation outside a substitution, aligned with its bit |
| exzFlag | output | 1 | Excessive-zeros event, one bit period long |

## Verification
Four properties are checked on every cycle: the outputs hold between strobes, bypass passes the rails with both flags low, a raised violation flag always comes with a decoded 1, and the excessive-zeros flag sits on a zero and drops after one bit. Only the directed scenarios can show the rest. These are the pipeline latency at each rate, the polarity bookkeeping that defines a violation, recognition and scrubbing of the B8ZS and both HDB3 patterns, and the exact position of the zero-run flag.

// File: rtl/linecode_pkg.sv
`timescale 1ns/1ps
package linecode_pkg;

  // Lengths of the substitution patterns (fixed by the line codes)
  localparam int B8ZS_LEN = 8;
  localparam int HDB3_LEN = 4;

  // One received symbol as it moves through the look-ahead pipeline
  typedef struct packed {
    logic pulse;  // a line pulse was present (never cleared)
    logic mark;   // decoded data bit
    logic viol;   // bipolar violation still to be reported
  } symT;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftEn;   // advance one bit period
    logic clrLong;   // scrub the incoming symbol and seven older ones
    logic clrShort;  // scrub the incoming symbol and three older ones
  } strobeT;

  function automatic logic isZero(symT s);
    return !s.pulse && !s.mark && !s.viol;
  endfunction

  function automatic logic isValid(symT s);
    return s.pulse && s.mark && !s.viol;
  endfunction

  function automatic logic isViol(symT s);
    return s.pulse && s.mark && s.viol;
  endfunction

endpackage

// File: rtl/bpd_datapath.sv
`timescale 1ns/1ps
module bpd_datapath
  import linecode_pkg::*;
#(
  parameter int T1_DEPTH = 8,
  parameter int E1_DEPTH = 4,
  parameter int DEPTH    = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   posRail,
  input  logic                   negRail,
  input  logic                   rateE1,
  input  strobeT                 stb,
  output symT                    inSym,
  output symT [B8ZS_LEN-2:0]     win,
  output symT                    outSym,
  output logic                   byP,
  output logic                   byN
);

  symT [DEPTH-1:0] pipe;
  symT [DEPTH-1:0] nextPipe;
  logic lastPol;
  logic polSeen;
  logic anyRail;
  logic bothRails;

  // Classify the incoming symbol against the polarity of the last pulse
  always_comb begin
    anyRail   = posRail | negRail;
    bothRails = posRail & negRail;
    inSym.pulse = anyRail;
    inSym.mark  = anyRail;
    inSym.viol  = bothRails | (anyRail & polSeen & (posRail == lastPol));
  end

  // Next pipeline contents, scrubbed where a substitution was recognised
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    localparam bit IN_LONG  = (g < B8ZS_LEN);
    localparam bit IN_SHORT = (g < HDB3_LEN);
    symT  src;
    logic scrub;
    if (g == 0) begin : g_head
      assign src = inSym;
    end else begin : g_body
      assign src = pipe[g-1];
    end
    assign scrub = (IN_LONG && stb.clrLong) || (IN_SHORT && stb.clrShort);
    assign nextPipe[g] = scrub ? symT'{src.pulse, 1'b0, 1'b0} : src;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipe    <= '0;
      lastPol <= 1'b0;
      polSeen <= 1'b0;
      byP     <= 1'b0;
      byN     <= 1'b0;
    end else if (stb.shiftEn) begin
      pipe <= nextPipe;
      byP  <= posRail;
      byN  <= negRail;
      if (anyRail && !bothRails) begin
        lastPol <= posRail;
        polSeen <= 1'b1;
      end
    end
  end

  assign win    = pipe[B8ZS_LEN-2:0];
  assign outSym = rateE1 ? pipe[E1_DEPTH-1] : pipe[T1_DEPTH-1];

endmodule

// File: rtl/bpd_control.sv
`timescale 1ns/1ps
module bpd_control
  import linecode_pkg::*;
#(
  parameter int T1_EXZ_LIMIT = 15,
  parameter int E1_EXZ_LIMIT = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitEn,
  input  logic               rateE1,
  input  logic               codeSel,
  input  logic               singleRail,
  input  symT                inSym,
  input  symT [B8ZS_LEN-2:0] win,
  input  logic               outPulse,
  output strobeT             stb,
  output logic               exzHit
);

  localparam int MAX_LIM = (T1_EXZ_LIMIT > E1_EXZ_LIMIT) ? T1_EXZ_LIMIT : E1_EXZ_LIMIT;
  localparam int SAT     = MAX_LIM + 1;
  localparam int CNT_W   = $clog2(SAT + 1);

  logic [CNT_W-1:0] zeroRun;
  logic [CNT_W-1:0] limit;
  logic longHit;
  logic shortHit;

  // Pattern recognition on the incoming symbol plus the newest stages
  always_comb begin
    longHit = singleRail & codeSel & !rateE1 & isValid(inSym) & isViol(win[0])
            & isZero(win[1]) & isValid(win[2]) & isViol(win[3]);
    for (int k = 4; k < B8ZS_LEN - 1; k++) begin
      longHit = longHit & isZero(win[k]);
    end
    shortHit = singleRail & codeSel & rateE1 & isViol(inSym)
             & isZero(win[0]) & isZero(win[1]) & !win[2].viol;
  end

  assign stb.shiftEn  = bitEn;
  assign stb.clrLong  = longHit;
  assign stb.clrShort = shortHit;

  // Run of pulse-free symbols that have already left the output tap
  assign limit = rateE1 ? CNT_W'(E1_EXZ_LIMIT) : CNT_W'(T1_EXZ_LIMIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zeroRun <= CNT_W'(SAT);
    end else if (bitEn) begin
      if (!singleRail) begin
        zeroRun <= CNT_W'(SAT);
      end else if (outPulse) begin
        zeroRun <= '0;
      end else if (zeroRun != CNT_W'(SAT)) begin
        zeroRun <= zeroRun + 1'b1;
      end
    end
  end

  assign exzHit = singleRail & !outPulse & (zeroRun == limit);

endmodule

// File: rtl/bipolar_decoder.sv
`timescale 1ns/1ps
module bipolar_decoder
  import linecode_pkg::*;
#(
  parameter int T1_DEPTH     = 8,
  parameter int E1_DEPTH     = 4,
  parameter int T1_EXZ_LIMIT = 15,
  parameter int E1_EXZ_LIMIT = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitEn,
  input  logic posRail,
  input  logic negRail,
  input  logic rateE1,
  input  logic codeSel,
  input  logic singleRail,
  output logic rxDataP,
  output logic rxDataN,
  output logic bpvFlag,
  output logic exzFlag
);

  // Both depths must cover their pattern lengths (8 and 4)
  localparam int DEPTH = (T1_DEPTH > E1_DEPTH) ? T1_DEPTH : E1_DEPTH;

  strobeT             stb;
  symT                inSym;
  symT [B8ZS_LEN-2:0] win;
  symT                outSym;
  logic               byP;
  logic               byN;
  logic               exzHit;

  bpd_control #(
    .T1_EXZ_LIMIT(T1_EXZ_LIMIT),
    .E1_EXZ_LIMIT(E1_EXZ_LIMIT)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .bitEn      (bitEn),
    .rateE1     (rateE1),
    .codeSel    (codeSel),
    .singleRail (singleRail),
    .inSym      (inSym),
    .win        (win),
    .outPulse   (outSym.pulse),
    .stb        (stb),
    .exzHit     (exzHit)
  );

  bpd_datapath #(
    .T1_DEPTH(T1_DEPTH),
    .E1_DEPTH(E1_DEPTH),
    .DEPTH   (DEPTH)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .posRail (posRail),
    .negRail (negRail),
    .rateE1  (rateE1),
    .stb     (stb),
    .inSym   (inSym),
    .win     (win),
    .outSym  (outSym),
    .byP     (byP),
    .byN     (byN)
  );

  assign rxDataP = singleRail ? outSym.mark : byP;
  assign rxDataN = singleRail ? 1'b0 : byN;
  assign bpvFlag = singleRail & outSym.viol;
  assign exzFlag = exzHit;

endmodule

// File: rtl/bpd_checks.sv
`timescale 1ns/1ps
module bpd_checks (
  input logic clk,
  input logic rstN,
  input logic bitEn,
  input logic posRail,
  input logic negRail,
  input logic rateE1,
  input logic codeSel,
  input logic singleRail,
  input logic rxDataP,
  input logic rxDataN,
  input logic bpvFlag,
  input logic exzFlag
);

  // R2: outputs hold while no strobe and no mode change
  a_r2_hold_between_bits: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(bitEn) && $stable(rateE1) && $stable(codeSel) && $stable(singleRail))
    |-> ($stable(rxDataP) && $stable(rxDataN) && $stable(bpvFlag) && $stable(exzFlag)));

  // R4: a reported violation is always decoded as one
  a_r4_bpv_is_one: assert property (@(posedge clk) disable iff (!rstN)
    bpvFlag |-> rxDataP);

  // R10: zero-run event sits on a zero bit without a violation
  a_r10_exz_on_zero: assert property (@(posedge clk) disable iff (!rstN)
    exzFlag |-> (!rxDataP && !bpvFlag));

  // R10/R11: the zero-run event lasts a single bit period
  a_r11_exz_one_bit: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(exzFlag) && $past(bitEn) && $stable(rateE1) && $stable(singleRail))
    |-> !exzFlag);

  // R12: bypass passes the rails sampled at the last strobe
  a_r12_bypass_pass: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(bitEn) && !singleRail)
    |-> (rxDataP == $past(posRail) && rxDataN == $past(negRail)));

  // R12: no status events in bypass
  a_r12_bypass_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !singleRail |-> (!bpvFlag && !exzFlag));

endmodule

bind bipolar_decoder bpd_checks u_checks (
  .clk        (clk),
  .rstN       (rstN),
  .bitEn      (bitEn),
  .posRail    (posRail),
  .negRail    (negRail),
  .rateE1     (rateE1),
  .codeSel    (codeSel),
  .singleRail (singleRail),
  .rxDataP    (rxDataP),
  .rxDataN    (rxDataN),
  .bpvFlag    (bpvFlag),
  .exzFlag    (exzFlag)
);

// File: tb/sim_bipolar_decoder.sv
`timescale 1ns/1ps
module sim_bipolar_decoder;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0;
  logic posRail = 1'b0;
  logic negRail = 1'b0;
  logic rateE1 = 1'b0;
  logic codeSel = 1'b0;
  logic singleRail = 1'b1;
  logic rxDataP, rxDataN, bpvFlag, exzFlag;

  int checks = 0;
  int errors = 0;

  logic stP [64];
  logic stN [64];
  logic capP [64];
  logic capN [64];
  logic capB [64];
  logic capE [64];
  int   nCap;

  always #10 clk = ~clk;

  bipolar_decoder u0 (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .posRail(posRail), .negRail(negRail),
    .rateE1(rateE1), .codeSel(codeSel), .singleRail(singleRail),
    .rxDataP(rxDataP), .rxDataN(rxDataN), .bpvFlag(bpvFlag), .exzFlag(exzFlag)
  );

  task automatic check(string req, string what, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; bitEn = 1'b0; posRail = 1'b0; negRail = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic setMode(logic rate, logic code, logic single);
    rateE1 = rate; codeSel = code; singleRail = single;
    doReset();
  endtask

  task automatic clearStim();
    for (int i = 0; i < 64; i++) begin
      stP[i] = 1'b0; stN[i] = 1'b0;
    end
  endtask

  task automatic setSym(int idx, logic p, logic n);
    stP[idx] = p; stN[idx] = n;
  endtask

  // One bit period: strobe, then sample twice before the next strobe (R2)
  task automatic tick(logic p, logic n);
    logic [3:0] early, late;
    @(negedge clk);
    posRail = p; negRail = n; bitEn = 1'b1;
    @(negedge clk);
    bitEn = 1'b0;
    early = {rxDataP, rxDataN, bpvFlag, exzFlag};
    repeat (2) @(negedge clk);
    late = {rxDataP, rxDataN, bpvFlag, exzFlag};
    check("R2", $sformatf("hold in bit %0d", nCap), late, early);
    capP[nCap] = rxDataP; capN[nCap] = rxDataN;
    capB[nCap] = bpvFlag; capE[nCap] = exzFlag;
    nCap++;
  endtask

  task automatic runStream(int len);
    nCap = 0;
    for (int i = 0; i < len; i++) tick(stP[i], stN[i]);
  endtask

  task automatic checkRun(string dTag, string bTag, string eTag, int lat, int n,
                          longint dM, longint bM, longint eM);
    for (int i = 0; i < n; i++) begin
      check(dTag, $sformatf("data of symbol %0d", i), {3'b0, capP[i+lat]}, {3'b0, dM[i]});
      check(bTag, $sformatf("bpv of symbol %0d", i), {3'b0, capB[i+lat]}, {3'b0, bM[i]});
      check(eTag, $sformatf("exz of symbol %0d", i), {3'b0, capE[i+lat]}, {3'b0, eM[i]});
      check("R3", $sformatf("negative output at %0d", i), {3'b0, capN[i+lat]}, 4'b0);
    end
  endtask

  task automatic testReset();
    setMode(1'b0, 1'b0, 1'b1);
    check("R1", "outputs after reset", {rxDataP, rxDataN, bpvFlag, exzFlag}, 4'b0);
  endtask

  // AMI with isolated violation (R4) and both-rail symbol (R5)
  task automatic testAmi(logic rate);
    int lat;
    lat = rate ? 3 : 7;
    setMode(rate, 1'b0, 1'b1);
    clearStim();
    setSym(0, 1, 0); setSym(2, 0, 1); setSym(4, 1, 0);
    setSym(5, 1, 0); setSym(6, 0, 1); setSym(7, 1, 1);
    runStream(8 + lat + 1);
    checkRun("R3", "R4 R5", "R10", lat, 8, 64'hF5, 64'hA0, 64'h0);
  endtask

  // B8ZS stream; with code 0 it is plain AMI (R6)
  task automatic testB8zs(logic code);
    setMode(1'b0, code, 1'b1);
    clearStim();
    setSym(0, 1, 0); setSym(4, 1, 0); setSym(5, 0, 1); setSym(7, 0, 1);
    setSym(8, 1, 0); setSym(9, 0, 1); setSym(10, 0, 1);
    runStream(11 + 8);
    if (code)
      checkRun("R6", "R9", "R10", 7, 11, 64'h601, 64'h400, 64'h0);
    else
      checkRun("R6", "R6", "R10", 7, 11, 64'h7B1, 64'h490, 64'h0);
  endtask

  // HDB3: 000V (R7), B00V (R8), stray violation (R9), zero run (R11)
  task automatic testHdb3();
    setMode(1'b1, 1'b1, 1'b1);
    clearStim();
    setSym(0, 1, 0); setSym(4, 1, 0); setSym(5, 0, 1); setSym(8, 0, 1);
    setSym(9, 1, 0); setSym(10, 1, 0);
    runStream(17 + 4);
    checkRun("R7 R8", "R9", "R11", 3, 17, 64'h601, 64'h400, 64'h4000);
  endtask

  // T1 zero run: flag on the 16th zero only (R10)
  task automatic testExzT1();
    setMode(1'b0, 1'b0, 1'b1);
    clearStim();
    setSym(0, 1, 0); setSym(21, 0, 1);
    runStream(22 + 8);
    checkRun("R3", "R4", "R10", 7, 22, 64'h200001, 64'h0, 64'h10000);
  endtask

  // Bypass passes raw rails, flags stay low (R12)
  task automatic testBypass();
    setMode(1'b1, 1'b1, 1'b0);
    clearStim();
    setSym(0, 1, 0); setSym(1, 0, 1); setSym(2, 1, 1);
    setSym(4, 1, 0); setSym(5, 1, 0);
    runStream(6);
    for (int i = 0; i < 6; i++) begin
      check("R12", $sformatf("rails of symbol %0d", i), {2'b0, capP[i], capN[i]}, {2'b0, stP[i], stN[i]});
      check("R12", $sformatf("flags of symbol %0d", i), {2'b0, capB[i], capE[i]}, 4'b0);
    end
  endtask

  initial begin
    testReset();
    testAmi(1'b0);
    testAmi(1'b1);
    testB8zs(1'b1);
    testB8zs(1'b0);
    testHdb3();
    testExzT1();
    testBypass();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule